// File: doc/BRIEF.md
# Single-Channel Memory-to-Memory DMA Engine

This block is one DMA channel. It copies a run of data elements from a source address to a destination address over a simple read/write master port. Each element is read and then written, so every element costs one read phase and one write phase. Software configures the channel through plain configuration pins and then pulses a start strobe. The channel captures the configuration on that strobe and keeps it until the job finishes.

The job length is set by two numbers. One is the number of elements in a block (1 to 16). The other is the number of blocks (1 to 65536). The job may run on its own as soon as it is started, or it may be paced by a peripheral request line. When it is paced, three modes decide how the request gates the work:
- one block per request;
- one request for the whole job;
- elements move only while the request is held.

At the end of a job the channel drops busy and raises an interrupt. A bus error ends the job early and sets an error flag instead.

Top module: `dma_xfer_chan`

## Requirements
- R1: After reset, `busy`, `irq`, `err_flag`, `dack` and `m_req` are all 0.
- R2: With `cfg_use_req`=0, a `sw_start` pulse runs the whole job to completion without looking at `dreq`.
- R3: `cfg_size` selects the element width: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. The width is shown on `m_size` during every bus phase. Write data is right-justified, with all bits above the element width at zero.
- R4: When `cfg_src_fix`=0 the source address advances by the element width after each element; when it is 1 the source address stays fixed. `cfg_dst_fix` does the same for the destination address.
- R5: `cfg_blk_m1` holds the elements per block minus one, so the range is 1 to 16.
- R6: `cfg_cnt_m1` holds the number of blocks minus one, so the range is 1 to 65536. A job moves (cfg_blk_m1+1)*(cfg_cnt_m1+1) elements.
- R7: Block mode (`cfg_mode`=0, `cfg_use_req`=1): each `dreq` seen while the channel waits moves exactly one block. `dack` then pulses for one cycle after that block's last write, and the channel waits for the next request.
- R8: Burst mode (`cfg_mode`=1, `cfg_use_req`=1): one `dreq` moves the whole job, and `dack` pulses once at the end. Mode code 3 acts as burst.
- R9: Demand mode (`cfg_mode`=2, `cfg_use_req`=1): `dreq` is sampled before each element. An element starts only if `dreq` is high. An element that has already started always finishes. `dack` pulses after every element.
- R10: On the acknowledge of the final write, `busy` falls and `irq` rises on the same clock edge. `irq` stays high until `irq_clr` is pulsed or a new job is started.
- R11: An `m_err` returned with `m_ack` ends the job at once. `busy` falls, `err_flag` is set, `irq` stays low and no further bus requests are made. The next start clears `err_flag`.
- R12: While `m_req` is high and `m_ack` is low, `m_req`, `m_we`, `m_addr` and `m_wdata` hold their values.
- R13: A `sw_start` pulse while `busy` is high is ignored. The running job keeps its captured configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_start | input | 1 | Start strobe; captures the configuration when the channel is idle |
| irq_clr | input | 1 | Clears the completion flag |
| cfg_src | input | 32 | Source start address |
| cfg_dst | input | 32 | Destination start address |
| cfg_size | input | 2 | Element width code |
| cfg_mode | input | 2 | Request pacing mode |
| cfg_use_req | input | 1 | 1: paced by `dreq`; 0: runs freely once started |
| cfg_src_fix | input | 1 | Hold the source address fixed |
| cfg_dst_fix | input | 1 | Hold the destination address fixed |
| cfg_blk_m1 | input | 4 | Elements per block minus one |
| cfg_cnt_m1 | input | 16 | Blocks per job minus one |
| dreq | input | 1 | Peripheral request |
| dack | output | 1 | One-cycle acknowledge to the peripheral |
| busy | output | 1 | Channel enabled, job in progress |
| irq | output | 1 | Completion interrupt |
| err_flag | output | 1 | Job ended by a bus error |
| m_req | output | 1 | Bus request |
| m_we | output | 1 | 1 = write phase, 0 = read phase |
| m_addr | output | 32 | Bus byte address |
| m_size | output | 2 | Bus element width code |
| m_wdata | output | 32 | Write data, right-justified |
| m_rdata | input | 32 | Read data, right-justified |
| m_ack | input | 1 | Phase complete |
| m_err | input | 1 | Phase failed (valid with `m_ack`) |

## Verification
The free-running copy is swept over every element width, all four fixed/increment address combinations, several block and count shapes, and bus latencies of 0 to 2 wait cycles. The resulting destination bytes are compared with an arithmetic model:
- a fixed source shows up as one value repeated across the destination;
- a fixed destination shows up as only the last element surviving;
- a wrong stride or a wrong count shows up as a shifted or truncated image.

Each paced mode is driven with its own request pattern:
- block mode gets single requests with idle gaps between them, which separates one block per request from the whole job;
- burst mode gets one short pulse;
- demand mode has its request held and then dropped part way through the job.

The element counts and acknowledge counts then tell the three pacing rules apart. An error injected on a mid-job read, and a second start pulse during a run, cover early termination and the ignored restart.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [1:0] {
        XM_BLOCK  = 2'd0,
        XM_BURST  = 2'd1,
        XM_DEMAND = 2'd2,
        XM_RSVD   = 2'd3
    } xfer_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARB  = 2'd1,
        ST_RD   = 2'd2,
        ST_WR   = 2'd3
    } ch_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              fixed_i,
    input  logic [1:0]        size_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              fixed;
        logic [1:0]        size;
    } as_t;

    as_t q, d;
    logic [ADDR_W-1:0] stride;

    always_comb begin
        stride = {{(ADDR_W-4){1'b0}}, 4'(4'd1 << q.size)};
        d = q;
        if (load_i) begin
            d.addr  = base_i;
            d.fixed = fixed_i;
            d.size  = size_i;
        end else if (step_i && !q.fixed) begin
            d.addr = q.addr + stride;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign addr_o = q.addr;

    // R4
    fixed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.fixed && !load_i) |=> $stable(addr_o));

endmodule

// File: rtl/dma_len_track.sv
module dma_len_track #(
    parameter int BLK_W = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [BLK_W-1:0] blk_m1_i,
    input  logic [CNT_W-1:0] cnt_m1_i,
    input  logic             step_i,
    output logic             blk_last_o,
    output logic             all_last_o
);
    typedef struct packed {
        logic [BLK_W-1:0] blk_rl;
        logic [BLK_W-1:0] blk_left;
        logic [CNT_W-1:0] cnt_left;
    } lt_t;

    lt_t q, d;

    always_comb begin
        d = q;
        if (load_i) begin
            d.blk_rl   = blk_m1_i;
            d.blk_left = blk_m1_i;
            d.cnt_left = cnt_m1_i;
        end else if (step_i) begin
            if (q.blk_left == '0) begin
                d.blk_left = q.blk_rl;
                if (q.cnt_left != '0) d.cnt_left = q.cnt_left - 1'b1;
            end else begin
                d.blk_left = q.blk_left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign blk_last_o = (q.blk_left == '0);
    assign all_last_o = blk_last_o && (q.cnt_left == '0);

    // R6
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && !blk_last_o) |=> $stable(q.cnt_left));

endmodule

// File: rtl/dma_xfer_chan.sv
module dma_xfer_chan
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BLK_W  = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_start,
    input  logic              irq_clr,
    input  logic [ADDR_W-1:0] cfg_src,
    input  logic [ADDR_W-1:0] cfg_dst,
    input  logic [1:0]        cfg_size,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_use_req,
    input  logic              cfg_src_fix,
    input  logic              cfg_dst_fix,
    input  logic [BLK_W-1:0]  cfg_blk_m1,
    input  logic [CNT_W-1:0]  cfg_cnt_m1,
    input  logic              dreq,
    output logic              dack,
    output logic              busy,
    output logic              irq,
    output logic              err_flag,
    output logic              m_req,
    output logic              m_we,
    output logic [ADDR_W-1:0] m_addr,
    output logic [1:0]        m_size,
    output logic [DATA_W-1:0] m_wdata,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic              m_ack,
    input  logic              m_err
);
    localparam int N_PTR = 2;
    localparam int P_SRC = 0;
    localparam int P_DST = 1;

    typedef struct packed {
        ch_state_e         state;
        logic              en;
        logic              done;
        logic              err;
        logic              run;
        logic              dack;
        xfer_mode_e        mode;
        logic              use_req;
        logic [1:0]        size;
        logic [DATA_W-1:0] data;
    } ctl_t;

    ctl_t q, d;
    logic load, elem_done, go, fail;
    logic blk_last, all_last;

    logic [ADDR_W-1:0] base_v [N_PTR];
    logic              fix_v  [N_PTR];
    logic [ADDR_W-1:0] addr_v [N_PTR];

    assign base_v[P_SRC] = cfg_src;
    assign base_v[P_DST] = cfg_dst;
    assign fix_v[P_SRC]  = cfg_src_fix;
    assign fix_v[P_DST]  = cfg_dst_fix;

    for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
        dma_addr_step #(.ADDR_W(ADDR_W)) u_ptr (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (load),
            .base_i  (base_v[g]),
            .fixed_i (fix_v[g]),
            .size_i  (cfg_size),
            .step_i  (elem_done),
            .addr_o  (addr_v[g])
        );
    end

    dma_len_track #(.BLK_W(BLK_W), .CNT_W(CNT_W)) u_len (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .blk_m1_i   (cfg_blk_m1),
        .cnt_m1_i   (cfg_cnt_m1),
        .step_i     (elem_done),
        .blk_last_o (blk_last),
        .all_last_o (all_last)
    );

    always_comb begin
        d         = q;
        d.dack    = 1'b0;
        load      = 1'b0;
        elem_done = 1'b0;
        go        = 1'b0;
        fail      = 1'b0;
        if (irq_clr) d.done = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (sw_start) begin
                    load      = 1'b1;
                    d.en      = 1'b1;
                    d.done    = 1'b0;
                    d.err     = 1'b0;
                    d.run     = 1'b0;
                    d.mode    = xfer_mode_e'(cfg_mode);
                    d.use_req = cfg_use_req;
                    d.size    = cfg_size;
                    d.state   = ST_ARB;
                end
            end
            ST_ARB: begin
                go = !q.use_req || q.run || dreq;
                if (go) begin
                    d.state = ST_RD;
                    if (q.use_req && q.mode != XM_DEMAND) d.run = 1'b1;
                end
            end
            ST_RD: begin
                if (m_ack) begin
                    if (m_err) begin
                        fail = 1'b1;
                    end else begin
                        unique case (q.size)
                            SZ_BYTE: d.data = DATA_W'(m_rdata[7:0]);
                            SZ_HALF: d.data = DATA_W'(m_rdata[15:0]);
                            default: d.data = m_rdata;
                        endcase
                        d.state = ST_WR;
                    end
                end
            end
            ST_WR: begin
                if (m_ack) begin
                    if (m_err) begin
                        fail = 1'b1;
                    end else begin
                        elem_done = 1'b1;
                        if (all_last) begin
                            d.en    = 1'b0;
                            d.done  = 1'b1;
                            d.run   = 1'b0;
                            d.dack  = q.use_req;
                            d.state = ST_IDLE;
                        end else begin
                            d.state = ST_ARB;
                            if (q.use_req) begin
                                if (q.mode == XM_DEMAND) begin
                                    d.dack = 1'b1;
                                end else if (q.mode == XM_BLOCK && blk_last) begin
                                    d.dack = 1'b1;
                                    d.run  = 1'b0;
                                end
                            end
                        end
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
        if (fail) begin
            d.en    = 1'b0;
            d.err   = 1'b1;
            d.run   = 1'b0;
            d.state = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.mode  <= XM_BLOCK;
        end else begin
            q <= d;
        end
    end

    assign busy     = q.en;
    assign irq      = q.done;
    assign err_flag = q.err;
    assign dack     = q.dack;
    assign m_req    = (q.state == ST_RD) || (q.state == ST_WR);
    assign m_we     = (q.state == ST_WR);
    assign m_addr   = m_we ? addr_v[P_DST] : addr_v[P_SRC];
    assign m_size   = q.size;
    assign m_wdata  = q.data;

    // R12
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ack) |=> (m_req && $stable(m_we) && $stable(m_addr) && $stable(m_wdata)));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !m_req);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !busy);

    // R11
    err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_ack && m_err) |=> (!busy && err_flag && !m_req && !irq));

    // R9
    demand_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(m_req) && q.use_req && q.mode == XM_DEMAND) |-> $past(dreq));

endmodule

// File: tb/dma_xfer_chan_test.sv
module dma_xfer_chan_test;
    localparam int CLK_PER = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_start = 0, irq_clr = 0;
    logic [31:0] cfg_src = 0, cfg_dst = 0;
    logic [1:0] cfg_size = 0, cfg_mode = 0;
    logic cfg_use_req = 0, cfg_src_fix = 0, cfg_dst_fix = 0;
    logic [3:0] cfg_blk_m1 = 0;
    logic [15:0] cfg_cnt_m1 = 0;
    logic dreq = 0;
    logic dack, busy, irq, err_flag, m_req, m_we;
    logic [31:0] m_addr, m_wdata;
    logic [1:0] m_size;
    logic [31:0] m_rdata;
    logic m_ack, m_err;

    logic [7:0] mem [256];
    logic [7:0] expm [256];
    int wr_cnt, dack_n, sz_bad, wd_bad, lat, wt;
    logic [1:0] cur_size;
    logic err_on;
    logic [7:0] err_addr;
    int n_run = 0, n_fail = 0;

    always #(CLK_PER/2) clk = ~clk;

    dma_xfer_chan uut (
        .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .irq_clr(irq_clr),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_size(cfg_size), .cfg_mode(cfg_mode),
        .cfg_use_req(cfg_use_req), .cfg_src_fix(cfg_src_fix), .cfg_dst_fix(cfg_dst_fix),
        .cfg_blk_m1(cfg_blk_m1), .cfg_cnt_m1(cfg_cnt_m1), .dreq(dreq), .dack(dack),
        .busy(busy), .irq(irq), .err_flag(err_flag), .m_req(m_req), .m_we(m_we),
        .m_addr(m_addr), .m_size(m_size), .m_wdata(m_wdata), .m_rdata(m_rdata),
        .m_ack(m_ack), .m_err(m_err)
    );

    // Bus responder with programmable wait cycles
    initial begin
        m_ack = 0; m_err = 0; m_rdata = 0; wt = 0;
        wr_cnt = 0; dack_n = 0; sz_bad = 0; wd_bad = 0;
        lat = 0; cur_size = 0; err_on = 0; err_addr = 0;
        forever begin
            @(negedge clk);
            if (dack) dack_n++;
            if (m_ack) begin
                m_ack = 0; m_err = 0;
            end else if (m_req) begin
                if (m_size != cur_size) sz_bad++;
                if (wt < lat) wt++;
                else begin
                    logic [7:0] a;
                    wt = 0;
                    m_ack = 1;
                    a = m_addr[7:0];
                    if (err_on && !m_we && a == err_addr) m_err = 1;
                    else if (m_we) begin
                        for (int i = 0; i < (1 << m_size); i++)
                            mem[8'(a + 8'(i))] = m_wdata[8*i +: 8];
                        if (m_size == 2'd0 && m_wdata[31:8] != 0) wd_bad++;
                        if (m_size == 2'd1 && m_wdata[31:16] != 0) wd_bad++;
                        wr_cnt++;
                    end else begin
                        m_rdata = {mem[8'(a+8'd3)], mem[8'(a+8'd2)], mem[8'(a+8'd1)], mem[a]};
                    end
                end
            end
        end
    end

    task automatic chk(input string req, input logic ok, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i * 37 + seed + 1);
            expm[i] = mem[i];
        end
    endtask

    task automatic model(input int sz, input logic sf, input logic df, input int blk, input int cnt);
        int nb, e;
        nb = 1 << sz;
        e = (blk + 1) * (cnt + 1);
        for (int k = 0; k < e; k++) begin
            int s, dd;
            s  = 'h10 + (sf ? 0 : k * nb);
            dd = 'h80 + (df ? 0 : k * nb);
            for (int i = 0; i < nb; i++) expm[(dd + i) & 255] = expm[(s + i) & 255];
        end
    endtask

    function automatic int mism();
        int m = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== expm[i]) m++;
        return m;
    endfunction

    task automatic start(input int sz, input logic sf, input logic df, input int blk,
                         input int cnt, input int mode, input logic ur);
        @(negedge clk);
        cfg_src = 32'h10; cfg_dst = 32'h80; cfg_size = 2'(sz); cur_size = 2'(sz);
        cfg_src_fix = sf; cfg_dst_fix = df; cfg_blk_m1 = 4'(blk); cfg_cnt_m1 = 16'(cnt);
        cfg_mode = 2'(mode); cfg_use_req = ur;
        wr_cnt = 0; dack_n = 0;
        sw_start = 1;
        @(negedge clk);
        sw_start = 0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int runs = 0;
        int pairs_b [3] = '{0, 2, 3};
        int pairs_c [3] = '{0, 1, 3};
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", !busy && !irq && !err_flag && !dack && !m_req, {busy, irq, err_flag, m_req}, 0);
        rst_n = 1;
        @(negedge clk);

        // R2 R3 R4 R5 R6: free-running sweep
        for (int sz = 0; sz < 3; sz++)
            for (int fx = 0; fx < 4; fx++)
                for (int p = 0; p < 3; p++) begin
                    int e;
                    e = (pairs_b[p] + 1) * (pairs_c[p] + 1);
                    lat = runs % 3;
                    fill(runs);
                    model(sz, fx[0], fx[1], pairs_b[p], pairs_c[p]);
                    start(sz, fx[0], fx[1], pairs_b[p], pairs_c[p], 1, 1'b0);
                    wait_idle();
                    chk("R2/R4 image", mism() == 0, mism(), 0);
                    chk("R5/R6 count", wr_cnt == e, wr_cnt, e);
                    chk("R10 done", irq && !busy, irq, 1);
                    runs++;
                end
        chk("R3 size", sz_bad == 0, sz_bad, 0);
        chk("R3 justify", wd_bad == 0, wd_bad, 0);

        // R10 irq clear
        @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0;
        chk("R10 clear", !irq, irq, 0);

        // R7 block mode: 3 elements per block, 3 blocks
        lat = 1; fill(7); model(2, 0, 0, 2, 2);
        start(2, 0, 0, 2, 2, 0, 1'b1);
        for (int b = 0; b < 3; b++) begin
            repeat (6) @(negedge clk);
            chk("R7 idle", wr_cnt == 3 * b, wr_cnt, 3 * b);
            dreq = 1;
            while (!dack) @(negedge clk);
            dreq = 0;
            chk("R7 block", wr_cnt == 3 * (b + 1), wr_cnt, 3 * (b + 1));
        end
        wait_idle();
        chk("R7 image", mism() == 0, mism(), 0);
        chk("R7 dack", dack_n == 3, dack_n, 3);

        // R8 burst mode: one short pulse moves 16 elements
        lat = 0; fill(9); model(0, 0, 0, 3, 3);
        start(0, 0, 0, 3, 3, 1, 1'b1);
        repeat (4) @(negedge clk);
        chk("R8 wait", wr_cnt == 0, wr_cnt, 0);
        dreq = 1; @(negedge clk); dreq = 0;
        wait_idle();
        chk("R8 all", wr_cnt == 16 && mism() == 0, wr_cnt, 16);
        chk("R8 dack", dack_n == 1, dack_n, 1);

        // R9 demand mode
        lat = 0; fill(11); model(1, 0, 0, 3, 3);
        start(1, 0, 0, 3, 3, 2, 1'b1);
        dreq = 1;
        while (wr_cnt < 5) @(negedge clk);
        @(negedge clk); dreq = 0;
        repeat (20) @(negedge clk);
        chk("R9 stop", wr_cnt == 5 && busy, wr_cnt, 5);
        dreq = 1;
        wait_idle();
        dreq = 0;
        chk("R9 all", wr_cnt == 16 && mism() == 0, wr_cnt, 16);
        @(negedge clk);
        chk("R9 dack", dack_n == 16, dack_n, 16);

        // R11 bus error on third read
        lat = 0; fill(13); err_on = 1; err_addr = 8'h12;
        start(0, 0, 0, 7, 0, 1, 1'b0);
        wait_idle();
        chk("R11 flag", err_flag && !irq, {err_flag, irq}, 2);
        chk("R11 writes", wr_cnt == 2, wr_cnt, 2);
        repeat (10) @(negedge clk);
        chk("R11 quiet", wr_cnt == 2 && !m_req, wr_cnt, 2);
        err_on = 0;

        // R13 restart while busy ignored; R11 flag cleared by start
        lat = 2; fill(15); model(0, 0, 0, 15, 1);
        start(0, 0, 0, 15, 1, 1, 1'b0);
        chk("R11 clear", !err_flag, err_flag, 0);
        repeat (10) @(negedge clk);
        cfg_dst = 32'hC0; cfg_blk_m1 = 4'd0; sw_start = 1;
        @(negedge clk); sw_start = 0;
        wait_idle();
        chk("R13 image", mism() == 0, mism(), 0);
        chk("R13 count", wr_cnt == 32, wr_cnt, 32);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule